// File: doc/BRIEF.md
# MII Nibble Transmit Framer

This block takes packet bytes from a valid/ready/last byte stream and sends them on a 4-bit MII transmit interface. It runs on the transmit clock that the PHY supplies. For every packet it first sends the preamble and start-of-frame delimiter. It then passes the payload through, pads short payloads with zeros up to the Ethernet minimum, and appends a CRC-32 frame check sequence.

Software can select CRC bypass for a frame. In that case the payload already ends with its own four check bytes, and the framer sends it unchanged, with no padding and no computed FCS.

The interface has no transmit error pin. If the source runs dry before the end of a frame, the framer stops taking data. It closes the frame with the bit-inverted CRC of the bytes it has already sent, so that every receiver discards the frame.

Top module: `mii_tx_framer`

## Requirements
- R1: After reset, tx_en and s_ready are low and txd is 0.
- R2: A frame starts in the cycle after s_valid is seen high while idle. It begins with 15 nibbles of 5h followed by one nibble Dh, which puts bytes 55h (seven times) and D5h on the wire.
- R3: Each payload byte is sent low nibble first, then high nibble, unchanged, in stream order.
- R4: Unless bypass is selected, the framer appends the complement of the reflected CRC-32 (polynomial 04C11DB7h, preset to all ones) over payload and padding. The FCS goes out least significant nibble first, so bit 0 of the FCS word leaves first.
- R5: Without bypass, payloads shorter than 60 bytes are extended with zero bytes to 60 bytes before the FCS.
- R6: Payloads of 60 bytes or more get no padding.
- R7: The bypass input is sampled only when a frame starts. With bypass set, the frame ends right after the last payload byte, with no padding and no computed FCS.
- R8: If s_valid is low while s_ready is high, the framer takes no further bytes. It sends the uncomplemented CRC register of the bytes already sent, as 8 nibbles, and then lowers tx_en. No padding is added.
- R9: s_ready is high only while tx_en is high. txd is 0 whenever tx_en is low. Every frame holds an even number of nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY transmit clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| s_data | input | 8 | Payload byte from the source |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | Current byte is the last of the packet |
| s_ready | output | 1 | Byte is taken at this clock edge when s_valid is high |
| crc_bypass | input | 1 | Frame carries its own FCS; sampled at frame start |
| txd | output | 4 | MII transmit nibble |
| tx_en | output | 1 | MII transmit enable |

## Verification
The framer is driven with a 1-byte and a 10-byte payload, which must be padded. It is also driven with exactly 60 bytes, the boundary with no padding, and with 70 bytes, beyond it. Comparing these runs separates correct padding and CRC coverage from off-by-one errors at the threshold. A bypass frame flips the bypass input after the first byte, to show that the choice is latched at frame start. Two underflows are tested, one before and one after the padding threshold. They show that the inverted CRC covers exactly the bytes sent and that no padding follows an aborted frame.

// File: rtl/mii_tx_framer.sv
module mii_tx_framer #(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       crc_bypass,
  output logic [3:0] txd,
  output logic       tx_en
);
  localparam int MIN_DATA = MIN_FRAME - 4;
  localparam int CW = $clog2(MIN_DATA + 1);
  localparam logic [31:0] POLY = 32'hEDB88320;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_PAD, S_FCS} st_t;

  st_t         st;
  logic        hi, byp, bad, lastseen;
  logic [4:0]  ncnt;
  logic [7:0]  cur;
  logic [31:0] crc;
  logic [CW-1:0] cnt;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++)
      r = (r >> 1) ^ ((r[0] ^ d[k]) ? POLY : 32'h0);
    return r;
  endfunction

  wire [31:0] fcs_word = bad ? crc : ~crc;
  wire        padded   = (cnt == CW'(MIN_DATA));

  assign s_ready = (st == S_DATA) && !hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; hi <= 1'b0; byp <= 1'b0; bad <= 1'b0; lastseen <= 1'b0;
      ncnt <= '0; cur <= '0; crc <= '1; cnt <= '0;
      txd <= '0; tx_en <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          txd <= '0;
          tx_en <= 1'b0;
          if (s_valid) begin
            st <= S_PRE; tx_en <= 1'b1; txd <= 4'h5; ncnt <= 5'd1;
            byp <= crc_bypass; bad <= 1'b0; crc <= '1; cnt <= '0;
            hi <= 1'b0; lastseen <= 1'b0;
          end
        end
        S_PRE: begin
          txd <= (ncnt == 5'd15) ? 4'hD : 4'h5;
          ncnt <= ncnt + 5'd1;
          if (ncnt == 5'd15) st <= S_DATA;
        end
        S_DATA: begin
          if (!hi) begin
            if (s_valid) begin
              txd <= s_data[3:0];
              cur <= s_data;
              crc <= crc_step(crc, s_data);
              if (!padded) cnt <= cnt + 1'b1;
              lastseen <= s_last;
              hi <= 1'b1;
            end else begin
              txd <= crc[3:0];
              bad <= 1'b1;
              ncnt <= 5'd1;
              st <= S_FCS;
            end
          end else begin
            txd <= cur[7:4];
            hi <= 1'b0;
            if (lastseen) begin
              if (byp) begin
                st <= S_FCS; ncnt <= 5'd8;
              end else if (padded) begin
                st <= S_FCS; ncnt <= 5'd0;
              end else begin
                st <= S_PAD;
              end
            end
          end
        end
        S_PAD: begin
          txd <= '0;
          hi <= ~hi;
          if (!hi) begin
            crc <= crc_step(crc, 8'h00);
            cnt <= cnt + 1'b1;
          end else if (padded) begin
            st <= S_FCS; ncnt <= 5'd0;
          end
        end
        S_FCS: begin
          if (ncnt == 5'd8) begin
            tx_en <= 1'b0; txd <= '0; st <= S_IDLE;
          end else begin
            txd <= fcs_word[{ncnt[2:0], 2'b00} +: 4];
            ncnt <= ncnt + 5'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic [3:0] txd,
  input logic       tx_en
);
  logic       odd;
  logic [4:0] len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd <= 1'b0; len <= '0;
    end else if (tx_en) begin
      odd <= ~odd;
      if (len != 5'd31) len <= len + 5'd1;
    end else begin
      odd <= 1'b0; len <= '0;
    end
  end

  a_r2_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> txd == 4'h5);
  a_r9_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> tx_en);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd == 4'h0);
  a_r9_even_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> !odd);
  a_r9_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> len >= 5'd18);
  a_r8_underflow_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> (tx_en && !s_ready));
endmodule

bind mii_tx_framer mii_tx_framer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .txd(txd), .tx_en(tx_en)
);

// File: tb/mii_tx_framer_tb_top.sv
`timescale 1ns/1ps
module mii_tx_framer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0, crc_bypass = 1'b0;
  logic s_ready, tx_en;
  logic [3:0] txd;

  int checks = 0, failures = 0;
  logic [7:0] tx_bytes [128];
  logic [7:0] expb [256];
  logic [3:0] nib [1024];
  int ncount = 0;
  bit done = 1'b0, prev_en = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  mii_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .crc_bypass(crc_bypass), .txd(txd), .tx_en(tx_en)
  );

  always @(negedge clk) begin
    if (tx_en && ncount < 1024) begin
      nib[ncount] = txd;
      ncount++;
    end
    if (prev_en && !tx_en) done = 1'b1;
    prev_en = tx_en;
  end

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int first, input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = first; b < first + len; b++)
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ expb[b][k];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c;
  endfunction

  task automatic cmp_region(input string tag, input int b0, input int b1);
    int bad = 0, act = 0, exp = 0;
    for (int b = b0; b < b1; b++)
      for (int h = 0; h < 2; h++) begin
        logic [3:0] e;
        e = h ? expb[b][7:4] : expb[b][3:0];
        if (2*b+h >= ncount || nib[2*b+h] !== e) begin
          if (bad == 0) begin
            act = (2*b+h < ncount) ? int'(nib[2*b+h]) : -1;
            exp = int'(e);
          end
          bad++;
        end
      end
    chk(tag, bad == 0, act, exp);
  endtask

  task automatic run_frame(input int n, input bit byp, input int abort_at,
                           input string fcs_tag, input string len_tag);
    int sent, pad, en, i;
    bit take, ab;
    logic [31:0] c, f;
    ab = abort_at < n;
    sent = ab ? abort_at : n;
    for (int b = 0; b < 7; b++) expb[b] = 8'h55;
    expb[7] = 8'hD5;
    for (int b = 0; b < sent; b++) expb[8+b] = tx_bytes[b];
    pad = (!byp && !ab && sent < 60) ? 60 - sent : 0;
    for (int b = 0; b < pad; b++) expb[8+sent+b] = 8'h00;
    c = ref_crc(8, sent + pad);
    f = ab ? c : ~c;
    en = 8 + sent + pad;
    if (!(byp && !ab)) begin
      for (int b = 0; b < 4; b++) expb[en+b] = f[8*b +: 8];
      en += 4;
    end
    ncount = 0; done = 1'b0;
    @(negedge clk);
    crc_bypass = byp; i = 0; s_valid = 1'b1; s_data = tx_bytes[0]; s_last = (n == 1);
    take = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (take) begin
        i++;
        crc_bypass = ~byp;
        if (i >= n || i == abort_at) begin
          s_valid = 1'b0; s_last = 1'b0;
        end else begin
          s_data = tx_bytes[i]; s_last = (i == n - 1);
        end
      end
      take = s_valid && s_ready;
    end
    s_valid = 1'b0; crc_bypass = 1'b0;
    @(negedge clk);
    chk(len_tag, ncount == 2*en, ncount, 2*en);
    cmp_region("R2", 0, 8);
    cmp_region("R3", 8, 8 + sent);
    if (pad > 0) cmp_region("R5", 8 + sent, 8 + sent + pad);
    if (!(byp && !ab)) cmp_region(fcs_tag, en - 4, en);
    chk("R9", txd == 4'h0 && !tx_en && !s_ready, {tx_en, s_ready, txd}, 0);
  endtask

  task automatic fill(input int n, input int seed);
    for (int b = 0; b < n; b++) tx_bytes[b] = 8'((b * 37 + seed) ^ (b >> 1));
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1", !tx_en && txd == 4'h0 && !s_ready, {tx_en, s_ready, txd}, 0);
  endtask

  task automatic test_short;   fill(10, 3);  run_frame(10, 1'b0, 999, "R4", "R5"); endtask
  task automatic test_single;  fill(1, 9);   run_frame(1, 1'b0, 999, "R4", "R5"); endtask
  task automatic test_exact;   fill(60, 21); run_frame(60, 1'b0, 999, "R4", "R6"); endtask
  task automatic test_long;    fill(70, 77); run_frame(70, 1'b0, 999, "R4", "R6"); endtask
  task automatic test_bypass;  fill(20, 5);  run_frame(20, 1'b1, 999, "R7", "R7"); endtask
  task automatic test_under_early; fill(30, 11); run_frame(30, 1'b0, 5, "R8", "R8"); endtask
  task automatic test_under_late;  fill(70, 13); run_frame(70, 1'b0, 64, "R8", "R8"); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_short();
    test_single();
    test_exact();
    test_long();
    test_bypass();
    test_under_early();
    test_under_late();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule